// File: doc/BRIEF.md
# Synthesiser Loop Divider and Phase Comparator

This block is the digital heart of a frequency synthesiser loop. Two strobe inputs mark the edges of the reference clock and of the prescaled oscillator, both sampled in one system clock domain. A fixed reference divider turns the reference strobes into the comparison rate (512 by default, so a 4 MHz reference gives 7.8125 kHz). A programmable divider with a 15-bit ratio turns the prescaled oscillator strobes into the divided feedback signal. When the loop settles, the oscillator runs at ratio × 8 × comparison frequency, because an external divide-by-8 prescaler sits ahead of the strobe input.

A phase-frequency comparator built from two edge-set flags compares the two divided signals and issues pump-up and pump-down requests. A lock detector watches the width of those requests and raises a lock flag after a run of narrow ones. Four control bits from the register interface shape the outputs: one selects the high or low pump current, one silences the pump, one turns off the drive amplifier, and one routes both comparator inputs onto the two upper port pins for test in place of their programmed states.

Top module: `pll_core`

## Requirements
- R1: The reference divider produces one comparison event every REF_DIV reference strobes (default 512); its square wave is high for the first REF_DIV/2 strobes after each event.
- R2: The programmable divider produces one event every N prescaled strobes, where N is the 15-bit ratio; ratios 0 and 1 divide by 2; its square wave is high for ceil(N/2) strobes after each event.
- R3: A ratio written in the middle of a division cycle does not change that cycle; it is loaded at the next terminal count and governs the cycle after.
- R4: When the reference event comes first, pump_up is asserted until the divider event arrives; once both flags are set they stay set together for at most RST_DLY cycles before both clear.
- R5: When the divider event comes first, pump_dn is asserted until the reference event arrives.
- R6: locked goes to 1 after LOCK_N consecutive comparisons whose request width (cycles with either flag set) is at most LOCK_TOL; it rises only in the cycle after such a request ends.
- R7: A request wider than LOCK_TOL cycles clears locked in the next cycle, before the request ends.
- R8: While pump_off is 1, pump_up and pump_dn are both 0.
- R9: pump_hi follows cp_sel: 1 requests the high pump current (about 170 µA), 0 the low current (about 50 µA).
- R10: While drv_off is 1, drv_en is 0; otherwise it is 1.
- R11: port_on equals port_set when test_route is 0; when test_route is 1, bit PORT_W-2 carries the comparison square wave and bit PORT_W-1 the divider square wave, and the lower bits still follow port_set.
- R12: After reset both pump requests and locked are 0, and both dividers restart so that the first strobe of each produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle strobe per reference clock edge |
| vco_en | input | 1 | One-cycle strobe per prescaled oscillator edge |
| ratio | input | RATIO_W | Programmable divider ratio |
| cp_sel | input | 1 | Pump current select (1 high, 0 low) |
| pump_off | input | 1 | Forces both pump requests inactive |
| drv_off | input | 1 | Turns the drive amplifier off |
| test_route | input | 1 | Routes comparator inputs to the two upper port bits |
| port_set | input | PORT_W | Programmed port states (1 = on) |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_hi | output | 1 | High pump current selected |
| drv_en | output | 1 | Drive amplifier enable |
| port_on | output | PORT_W | Port drive states after test routing |
| locked | output | 1 | Phase lock flag |

## Verification
Each divider event is registered one cycle after the strobe that ends the count, the comparator flags one cycle later, and the lock flag one cycle after a request ends or exceeds its width, while the control bits, pump_hi, drv_en and the port mux respond in the same cycle. The bench samples on the falling clock edge and measures divider behaviour as rise-to-rise intervals and high-sample counts on the routed port bits, so the fixed pipeline offset cancels out. Lock checks are placed a whole comparison period away from the predicted event ends, and combinational controls are checked a fraction of a cycle after they change.

// File: rtl/pll_pkg.sv
package pll_pkg;

   typedef struct packed {
      logic hi_cur;
      logic pump_off;
      logic drv_off;
      logic test_route;
   } pll_ctrl_t;

   function automatic int unsigned pll_cw(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pll_refdiv.sv
module pll_refdiv #(
   parameter int DIV = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic pulse,
   output logic sq
);
   localparam int CW   = pll_pkg::pll_cw(DIV);
   localparam int HALF = DIV / 2;

   if (DIV < 2) begin : g_bad_div
      $error("pll_refdiv: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (tick) cnt <= cnt - 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else if (tick) begin
            if (cnt == '0) cnt <= CW'(DIV - 1);
            else           cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= tick && (cnt == '0);
   end

   assign sq = (cnt >= CW'(HALF));
endmodule

// File: rtl/pll_progdiv.sv
module pll_progdiv #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] ratio,
   output logic         pulse,
   output logic         sq
);
   if (W < 2) begin : g_bad_w
      $error("pll_progdiv: W must be at least 2");
   end

   logic [W-1:0] cnt;
   logic [W-1:0] half;
   logic [W-1:0] eff;

   assign eff = (ratio < W'(2)) ? W'(2) : ratio;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         half  <= W'(1);
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            if (cnt == '0) begin
               cnt   <= eff - 1'b1;
               half  <= eff >> 1;
               pulse <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   assign sq = (cnt >= half);
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_p,
   input  logic div_p,
   output logic up_q,
   output logic dn_q
);
   localparam int DW = pll_pkg::pll_cw(DLY + 1);

   if (DLY < 1) begin : g_bad_dly
      $error("pll_pfd: DLY must be at least 1");
   end

   logic [DW-1:0] dly;
   logic          both;
   logic          clr;

   assign both = up_q & dn_q;
   assign clr  = both && (dly == DW'(DLY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
         dly  <= '0;
      end else begin
         up_q <= clr ? ref_p : (up_q | ref_p);
         dn_q <= clr ? div_p : (dn_q | div_p);
         if (both && !clr) dly <= dly + 1'b1;
         else              dly <= '0;
      end
   end
endmodule

// File: rtl/pll_lockdet.sv
module pll_lockdet #(
   parameter int TOL  = 4,
   parameter int NEED = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   output logic lock
);
   localparam int WW = pll_pkg::pll_cw(TOL + 2);
   localparam int GW = pll_pkg::pll_cw(NEED + 1);

   if (NEED < 1) begin : g_bad_need
      $error("pll_lockdet: NEED must be at least 1");
   end

   logic [WW-1:0] wcnt;
   logic [GW-1:0] good;
   logic          narrow_end;

   assign narrow_end = !act && (wcnt != '0) && (wcnt <= WW'(TOL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         good <= '0;
         lock <= 1'b0;
      end else if (act) begin
         if (wcnt <= WW'(TOL)) wcnt <= wcnt + 1'b1;
         if (wcnt == WW'(TOL)) begin
            good <= '0;
            lock <= 1'b0;
         end
      end else begin
         wcnt <= '0;
         if (narrow_end) begin
            if (int'(good) < NEED) good <= good + 1'b1;
            if (int'(good) + 1 >= NEED) lock <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pll_core.sv
module pll_core #(
   parameter int REF_DIV  = 512,
   parameter int RATIO_W  = 15,
   parameter int RST_DLY  = 2,
   parameter int LOCK_TOL = 4,
   parameter int LOCK_N   = 4,
   parameter int PORT_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_en,
   input  logic               vco_en,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               cp_sel,
   input  logic               pump_off,
   input  logic               drv_off,
   input  logic               test_route,
   input  logic [PORT_W-1:0]  port_set,
   output logic               pump_up,
   output logic               pump_dn,
   output logic               pump_hi,
   output logic               drv_en,
   output logic [PORT_W-1:0]  port_on,
   output logic               locked
);
   import pll_pkg::*;

   localparam int TP_CMP = PORT_W - 2;
   localparam int TP_DIV = PORT_W - 1;

   if (PORT_W < 2) begin : g_bad_port
      $error("pll_core: PORT_W must be at least 2");
   end
   if (LOCK_TOL < RST_DLY) begin : g_bad_tol
      $error("pll_core: LOCK_TOL must cover RST_DLY");
   end

   pll_ctrl_t ctrl;
   logic fcomp_p, fcomp_sq;
   logic fdiv_p, fdiv_sq;
   logic pfd_up, pfd_dn;

   assign ctrl = '{hi_cur: cp_sel, pump_off: pump_off,
                   drv_off: drv_off, test_route: test_route};

   pll_refdiv #(.DIV(REF_DIV)) u_ref (
      .clk(clk), .rst_n(rst_n), .tick(ref_en),
      .pulse(fcomp_p), .sq(fcomp_sq));

   pll_progdiv #(.W(RATIO_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(vco_en), .ratio(ratio),
      .pulse(fdiv_p), .sq(fdiv_sq));

   pll_pfd #(.DLY(RST_DLY)) u_pfd (
      .clk(clk), .rst_n(rst_n), .ref_p(fcomp_p), .div_p(fdiv_p),
      .up_q(pfd_up), .dn_q(pfd_dn));

   pll_lockdet #(.TOL(LOCK_TOL), .NEED(LOCK_N)) u_lock (
      .clk(clk), .rst_n(rst_n), .act(pfd_up | pfd_dn), .lock(locked));

   assign pump_up = pfd_up & ~ctrl.pump_off;
   assign pump_dn = pfd_dn & ~ctrl.pump_off;
   assign pump_hi = ctrl.hi_cur;
   assign drv_en  = ~ctrl.drv_off;

   for (genvar i = 0; i < PORT_W; i++) begin : g_port
      if (i == TP_CMP) begin : g_cmp
         assign port_on[i] = ctrl.test_route ? fcomp_sq : port_set[i];
      end else if (i == TP_DIV) begin : g_div
         assign port_on[i] = ctrl.test_route ? fdiv_sq : port_set[i];
      end else begin : g_plain
         assign port_on[i] = port_set[i];
      end
   end
endmodule

// File: rtl/pll_core_chk.sv
module pll_core_chk #(
   parameter int RST_DLY  = 2,
   parameter int LOCK_TOL = 4
) (
   input logic clk,
   input logic rst_n,
   input logic ref_en,
   input logic vco_en,
   input logic fcomp_p,
   input logic fdiv_p,
   input logic pfd_up,
   input logic pfd_dn,
   input logic act,
   input logic locked
);
   logic [15:0] both_cnt;
   logic [15:0] act_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_cnt <= '0;
         act_cnt  <= '0;
      end else begin
         both_cnt <= (pfd_up && pfd_dn) ? ((both_cnt == 16'hFFFF) ? both_cnt : both_cnt + 1'b1) : '0;
         act_cnt  <= act ? ((act_cnt > 16'(LOCK_TOL)) ? act_cnt : act_cnt + 1'b1) : '0;
      end
   end

   AST_FCOMP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fcomp_p |-> $past(ref_en)); // R1
   AST_FDIV_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fdiv_p |-> $past(vco_en)); // R2
   AST_BOTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (pfd_up && pfd_dn) |-> (both_cnt < 16'(RST_DLY))); // R4
   AST_LOCK_AT_EVENT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (!$past(act) && $past(act, 2))); // R6
   AST_WIDE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (act && act_cnt == 16'(LOCK_TOL)) |=> !locked); // R7
endmodule

bind pll_core pll_core_chk #(.RST_DLY(RST_DLY), .LOCK_TOL(LOCK_TOL)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
   .fcomp_p(fcomp_p), .fdiv_p(fdiv_p), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
   .act(pfd_up | pfd_dn), .locked(locked));

// File: tb/pll_core_test.sv
module pll_core_test;
   localparam int CLK_P   = 10;
   localparam int REF_DIV = 16;
   localparam int PW      = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_en = 1'b1, vco_en = 1'b1;
   logic [14:0] ratio = 15'd16;
   logic cp_sel = 1'b0, pump_off = 1'b0, drv_off = 1'b0, test_route = 1'b0;
   logic [PW-1:0] port_set = '0;
   logic pump_up, pump_dn, pump_hi, drv_en, locked;
   logic [PW-1:0] port_on;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_P / 2) clk = ~clk;

   pll_core #(.REF_DIV(REF_DIV)) uut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
      .ratio(ratio), .cp_sel(cp_sel), .pump_off(pump_off),
      .drv_off(drv_off), .test_route(test_route), .port_set(port_set),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi(pump_hi),
      .drv_en(drv_en), .port_on(port_on), .locked(locked));

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_rise(input int idx);
      logic prev;
      prev = port_on[idx];
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (port_on[idx] && !prev) break;
         prev = port_on[idx];
      end
   endtask

   // starts on a rise sample; counts samples to the next rise
   task automatic rise_gap(input int idx, input int chg_at, input logic [14:0] nr,
                           output int per, output int hi);
      logic prev;
      prev = 1'b1;
      per = 0;
      hi = 1;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         per++;
         if (per == chg_at) ratio = nr;
         if (port_on[idx] && !prev) break;
         if (port_on[idx]) hi++;
         prev = port_on[idx];
      end
   endtask

   task automatic run_count(input int n, output int ups, output int dns);
      ups = 0;
      dns = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pump_up) ups++;
         if (pump_dn) dns++;
      end
   endtask

   initial begin
      int per, hi, ups, dns, expn;
      // R12 reset state
      #1;
      chk("R12 pump_up in reset", int'(pump_up), 0);
      chk("R12 pump_dn in reset", int'(pump_dn), 0);
      chk("R12 locked in reset", int'(locked), 0);
      do_reset();

      // R9, R10 control bits
      for (int v = 0; v < 2; v++) begin
         cp_sel = v[0];
         drv_off = v[0];
         #1;
         chk("R9 pump_hi follows cp_sel", int'(pump_hi), v);
         chk("R10 drv_en inverse of drv_off", int'(drv_en), 1 - v);
      end
      cp_sel = 1'b0;
      drv_off = 1'b0;

      // R11 port pass-through, all patterns
      test_route = 1'b0;
      for (int p = 0; p < 64; p++) begin
         port_set = 6'(p);
         #1;
         chk("R11 port_on equals port_set", int'(port_on), p);
      end
      test_route = 1'b1;
      for (int p = 0; p < 64; p++) begin
         port_set = 6'(p);
         #1;
         chk("R11 low ports under test route", int'(port_on[3:0]), p % 16);
      end
      port_set = '0;

      // R1 comparison square wave on bit PW-2
      do_reset();
      wait_rise(PW - 2);
      rise_gap(PW - 2, -1, 15'd0, per, hi);
      rise_gap(PW - 2, -1, 15'd0, per, hi);
      chk("R1 comparison period", per, REF_DIV);
      chk("R1 comparison high time", hi, REF_DIV / 2);

      // R2 ratio sweep on bit PW-1
      for (int n = 0; n <= 40; n++) begin
         ratio = 15'(n);
         do_reset();
         wait_rise(PW - 1);
         rise_gap(PW - 1, -1, 15'd0, per, hi);
         rise_gap(PW - 1, -1, 15'd0, per, hi);
         expn = (n < 2) ? 2 : n;
         chk("R2 divider period", per, expn);
         chk("R2 divider high time", hi, (expn + 1) / 2);
      end
      ratio = 15'd1000;
      do_reset();
      wait_rise(PW - 1);
      rise_gap(PW - 1, -1, 15'd0, per, hi);
      chk("R2 divider period large", per, 1000);

      // R3 mid-cycle ratio change
      ratio = 15'd10;
      do_reset();
      wait_rise(PW - 1);
      rise_gap(PW - 1, -1, 15'd0, per, hi);
      rise_gap(PW - 1, 3, 15'd30, per, hi);
      chk("R3 current cycle keeps old ratio", per, 10);
      rise_gap(PW - 1, -1, 15'd0, per, hi);
      chk("R3 next cycle uses new ratio", per, 30);
      test_route = 1'b0;

      // R6 lock with matched ratio
      ratio = 15'd16;
      do_reset();
      repeat (32) @(negedge clk);
      chk("R6 not yet locked after two comparisons", int'(locked), 0);
      repeat (48) @(negedge clk);
      chk("R6 locked after run of narrow requests", int'(locked), 1);

      // R7, R4 ratio too high: reference leads
      ratio = 15'd20;
      run_count(60, ups, dns);
      chk("R7 lock lost on wide request", int'(locked), 0);
      run_count(200, ups, dns);
      chk("R4 reference leads gives more up", int'(ups > dns), 1);

      // R5 ratio too low: divider leads
      ratio = 15'd12;
      do_reset();
      run_count(240, ups, dns);
      chk("R5 divider leads gives more down", int'(dns > ups), 1);
      chk("R7 stays unlocked off frequency", int'(locked), 0);

      // R8 pump silenced
      pump_off = 1'b1;
      ratio = 15'd20;
      do_reset();
      run_count(240, ups, dns);
      chk("R8 no up while pump_off", ups, 0);
      chk("R8 no down while pump_off", dns, 0);
      pump_off = 1'b0;
      run_count(100, ups, dns);
      chk("R8 pumps return after pump_off clears", int'(ups > 0), 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule